// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast input clock by a programmable integer N and produces one single-clock pulse on `fp_o` per division period. It uses the pulse-swallow method. A dual-modulus prescaler divides by P or P+1. A 7-bit swallow counter holds the prescaler at P+1 for its first A output cycles. An 11-bit main counter counts B prescaler cycles in total. A mode input chooses the modulus pair, either 64/65 or 128/129. The prescaler is modelled here as a synchronous counter clocked by the input clock.

A new swallow value, main value and mode are captured when `load_i` is high. They are applied only at the next period boundary, so a period that is already running is never cut short. Out-of-range values are brought into range before they are used: the main value is raised to at least 3, and the swallow value is limited to the main value.

Top module: `pulse_swallow_divider`

## Requirements
- R1: While `rst_ni` is low, `fp_o` is 0. After reset the divider runs with swallow 0, main 3 and mode 0, so consecutive `fp_o` pulses are 192 clocks apart.
- R2: Each `fp_o` pulse is high for exactly one clock.
- R3: With `mode_i`=0, the spacing between consecutive `fp_o` pulses is N = 64*B + A clocks.
- R4: With `mode_i`=1, the spacing between consecutive `fp_o` pulses is N = 128*B + A clocks.
- R5: A swallow value of 0 gives N = P*B exactly.
- R6: A swallow value equal to the main value gives N = (P+1)*B.
- R7: A swallow value greater than the main value is treated as equal to the main value.
- R8: A main value below 3 is treated as 3.
- R9: Values loaded during a period take effect at the next boundary. The period in which the load happens keeps its old length, and the period after it has the new length.
- R10: Changes on `swallow_i`, `main_i` and `mode_i` while `load_i` is low do not change the division ratio.
- R11: The prescaler modulus changes only at a prescaler cycle boundary. The swallow count never exceeds the remaining main count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | High-rate input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| swallow_i | input | 7 | Swallow value A |
| main_i | input | 11 | Main counter value B |
| mode_i | input | 1 | Modulus pair select: 0 selects 64/65, 1 selects 128/129 |
| load_i | input | 1 | Captures swallow_i, main_i and mode_i for the next period |
| fp_o | output | 1 | One-clock pulse, once per division period |

## Verification
`fp_o` rises one clock after the terminal clock of a period, so the spacing between two consecutive pulses equals N exactly. The bench therefore measures N by counting falling clock edges from one high sample of `fp_o` to the next. A load sampled on any rising edge applies at the first period boundary at or after that edge. For this reason the bench discards the period that is running when it loads and measures the period that follows. The exception is the R9 scenario, which counts the running period on purpose to confirm that it keeps its old length. The sample taken one falling edge after each pulse confirms that the pulse has already dropped.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int A_W    = 7;
  localparam int B_W    = 11;
  localparam int P_LO   = 64;
  localparam int P_HI   = 128;
  localparam int B_MIN  = 3;
  localparam int PC_W   = $clog2(P_HI + 2);

  typedef struct packed {
    logic           mode;
    logic [A_W-1:0] a;
    logic [B_W-1:0] b;
  } cfg_t;

  localparam cfg_t CFG_RST = '{mode: 1'b0, a: '0, b: B_W'(B_MIN)};

  function automatic cfg_t clamp_cfg(logic mode, logic [A_W-1:0] a, logic [B_W-1:0] b);
    cfg_t c;
    c.mode = mode;
    c.b    = (b < B_W'(B_MIN)) ? B_W'(B_MIN) : b;
    c.a    = (B_W'(a) > c.b) ? c.b[A_W-1:0] : a;
    return c;
  endfunction
endpackage

// File: rtl/psd_cfg_stage.sv
module psd_cfg_stage
  import psd_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           mode_i,
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  input  logic           bound_i,
  output cfg_t           act_o,
  output cfg_t           next_o
);
  cfg_t act_q, pend_q;
  logic pend_v_q;
  cfg_t in_c;

  assign in_c = clamp_cfg(mode_i, a_i, b_i);

  // config applied at the boundary: a same-cycle load wins over a pending one
  always_comb begin
    if (load_i)        next_o = in_c;
    else if (pend_v_q) next_o = pend_q;
    else               next_o = act_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q    <= CFG_RST;
      pend_q   <= CFG_RST;
      pend_v_q <= 1'b0;
    end else if (bound_i) begin
      act_q    <= next_o;
      pend_v_q <= 1'b0;
    end else if (load_i) begin
      pend_q   <= in_c;
      pend_v_q <= 1'b1;
    end
  end

  assign act_o = act_q;

  assert_b_min_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q.b >= B_W'(B_MIN));
  assert_a_le_b_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    B_W'(act_q.a) <= act_q.b);
  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bound_i |=> $stable(act_q));
endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler
  import psd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_i,
  input  logic mc_i,
  output logic tc_o
);
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] last_c;

  assign last_c = (mode_i ? PC_W'(P_HI - 1) : PC_W'(P_LO - 1)) + PC_W'(mc_i);
  assign tc_o   = (pc_q == last_c);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pc_q <= '0;
    else if (tc_o) pc_q <= '0;
    else           pc_q <= pc_q + 1'b1;
  end

  assert_pc_range_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_q <= PC_W'(P_HI));
endmodule

// File: rtl/psd_swallow.sv
module psd_swallow
  import psd_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           pre_tc_i,
  input  logic           bound_i,
  input  logic [A_W-1:0] a_load_i,
  output logic           mc_o,
  output logic [A_W-1:0] a_rem_o
);
  logic [A_W-1:0] a_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    a_q <= '0;
    else if (bound_i)               a_q <= a_load_i;
    else if (pre_tc_i && a_q != '0) a_q <= a_q - 1'b1;
  end

  assign mc_o    = (a_q != '0);
  assign a_rem_o = a_q;

  assert_mc_steady_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pre_tc_i |=> $stable(mc_o));
endmodule

// File: rtl/psd_main.sv
module psd_main
  import psd_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           pre_tc_i,
  input  logic [B_W-1:0] b_load_i,
  output logic           bound_o,
  output logic [B_W-1:0] b_rem_o,
  output logic           fp_o
);
  logic [B_W-1:0] b_q;
  logic           fp_q;

  assign bound_o = pre_tc_i && (b_q == B_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_q  <= B_W'(B_MIN);
      fp_q <= 1'b0;
    end else begin
      fp_q <= bound_o;
      if (bound_o)       b_q <= b_load_i;
      else if (pre_tc_i) b_q <= b_q - 1'b1;
    end
  end

  assign b_rem_o = b_q;
  assign fp_o    = fp_q;

  assert_b_nonzero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_q != '0);
  assert_fp_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_q |=> !fp_q);
endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider
  import psd_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [A_W-1:0] swallow_i,
  input  logic [B_W-1:0] main_i,
  input  logic           mode_i,
  input  logic           load_i,
  output logic           fp_o
);
  cfg_t           act_c, next_c;
  logic           bound_c, pre_tc_c, mc_c;
  logic [A_W-1:0] a_rem_c;
  logic [B_W-1:0] b_rem_c;

  psd_cfg_stage u_cfg (
    .clk_i, .rst_ni, .load_i, .mode_i,
    .a_i(swallow_i), .b_i(main_i), .bound_i(bound_c),
    .act_o(act_c), .next_o(next_c)
  );

  psd_prescaler u_pre (
    .clk_i, .rst_ni, .mode_i(act_c.mode), .mc_i(mc_c), .tc_o(pre_tc_c)
  );

  psd_swallow u_swl (
    .clk_i, .rst_ni, .pre_tc_i(pre_tc_c), .bound_i(bound_c),
    .a_load_i(next_c.a), .mc_o(mc_c), .a_rem_o(a_rem_c)
  );

  psd_main u_main (
    .clk_i, .rst_ni, .pre_tc_i(pre_tc_c), .b_load_i(next_c.b),
    .bound_o(bound_c), .b_rem_o(b_rem_c), .fp_o
  );

  assert_swallow_le_main_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    B_W'(a_rem_c) <= b_rem_c);
  assert_reset_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !fp_o);
endmodule

// File: tb/pulse_swallow_divider_bench.sv
module pulse_swallow_divider_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  swallow = '0;
  logic [10:0] main_v = '0;
  logic        mode = 1'b0;
  logic        load = 1'b0;
  logic        fp;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_swallow_divider u_pulse_swallow_divider (
    .clk_i(clk), .rst_ni(rst_n), .swallow_i(swallow), .main_i(main_v),
    .mode_i(mode), .load_i(load), .fp_o(fp)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_fp();
    do @(negedge clk); while (!fp);
  endtask

  // counts clocks from the current fp sample to the next; also checks pulse width
  task automatic count_to_fp(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) chk(int'(fp), 0, "R2 pulse width");
    end while (!fp);
  endtask

  task automatic apply(input logic m, input int a, input int b);
    @(negedge clk);
    mode = m; swallow = 7'(a); main_v = 11'(b); load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic run_ratio(input logic m, input int a, input int b, input int exp, input string tag);
    int n;
    apply(m, a, b);
    wait_fp();
    count_to_fp(n);
    chk(n, exp, tag);
    count_to_fp(n);
    chk(n, exp, tag);
  endtask

  task automatic t_reset();
    int n;
    chk(int'(fp), 0, "R1 fp low in reset");
    @(negedge clk); rst_n = 1'b1;
    wait_fp();
    count_to_fp(n);
    chk(n, 192, "R1 default ratio");
  endtask

  task automatic t_load_boundary();
    int n;
    apply(1'b0, 3, 8);          // N1 = 515
    wait_fp();
    count_to_fp(n);
    chk(n, 515, "R9 before load");
    n = 0;
    repeat (5) begin @(negedge clk); n++; end
    mode = 1'b1; swallow = 7'd2; main_v = 11'd5; load = 1'b1;   // N2 = 642
    @(negedge clk); n++;
    load = 1'b0;
    while (!fp) begin @(negedge clk); n++; end
    chk(n, 515, "R9 running period kept");
    count_to_fp(n);
    chk(n, 642, "R9 new ratio after boundary");
  endtask

  task automatic t_ignore();
    int n;
    apply(1'b0, 4, 6);          // 388
    mode = 1'b1; swallow = 7'd9; main_v = 11'd20;
    wait_fp();
    count_to_fp(n);
    chk(n, 388, "R10 inputs ignored without load");
    count_to_fp(n);
    chk(n, 388, "R10 inputs ignored without load");
  endtask

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    run_ratio(1'b0, 5, 10, 645, "R3 mode0 R11");
    run_ratio(1'b0, 0, 7, 448, "R5 A=0 mode0");
    run_ratio(1'b0, 10, 10, 650, "R6 A=B mode0 R11");
    run_ratio(1'b1, 3, 6, 771, "R4 mode1");
    run_ratio(1'b1, 0, 4, 512, "R5 A=0 mode1");
    run_ratio(1'b1, 127, 127, 16383, "R6 A=B mode1");
    run_ratio(1'b1, 7, 4, 516, "R7 A>B clamped");
    run_ratio(1'b0, 2, 1, 194, "R8 B=1 clamped");
    run_ratio(1'b0, 0, 0, 192, "R8 B=0 clamped");
    t_load_boundary();
    t_ignore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule